// File: doc/BRIEF.md
# Decision Feedback Equalizer Loop

This block is the digital decision loop of a serial receiver. Each cycle in which the sample-valid input is high, it takes one signed sample from the equalizing front end and builds a correction from the symbols it has already decided. Each past decision counts as +1 or -1 and is multiplied by the signed weight of its post-cursor tap. The block subtracts this correction from the sample with saturation and slices the result against zero to get a binary decision. That decision feeds straight back, so it shapes the correction for the very next sample. The block also outputs an error value for a later adaptation engine: the corrected sample minus the ideal level, where the ideal level is plus or minus a programmable reference amplitude.

The decision register is tap one. The register path from decision through subtraction and back to the slicer closes in a single cycle. Older decisions move through a chain of retiming registers, and taps two and beyond read from that chain. A registered flag reports tap settings whose total absolute weight is not strictly between zero and one. The loop trusts every decision it makes. A wrong decision therefore adds ISI to the following samples instead of removing it.

Top module: `dfe_loop`

## Requirements
- R1: The correction is the sum over taps of (+w when the stored decision bit is 1, -w when it is 0). It is scaled by 2^(SAMPLE_W-WEIGHT_W) sample units per weight LSB and subtracted from the sample. The decision is 1 (meaning +1) when the corrected value is greater than or equal to zero, so a corrected value of exactly zero decides 1.
- R2: Tap k (k = 1..NTAPS, weight field k-1 at bits [(k-1)*WEIGHT_W +: WEIGHT_W]) uses the decision made k valid samples earlier. The current sample's own decision never enters its correction.
- R3: The decision of an accepted sample is used by the sample accepted in the next cycle. The decision, error and decision-valid outputs are registered and appear one cycle after acceptance.
- R4: Taps two and beyond read decisions from a retiming shift chain that advances by one stage per valid sample.
- R5: The difference is saturated to the signed SAMPLE_W range, [-2^(SAMPLE_W-1), 2^(SAMPLE_W-1)-1].
- R6: The weight-range flag goes high one cycle after the weights hold a total absolute value of zero or of at least 2^(WEIGHT_W-1), and is low otherwise.
- R7: While sample-valid is low, the decision history, decision output and error output hold their values and decision-valid is low.
- R8: A synchronous reset clears the history to all -1 (bit 0), clears the decision, error and flag outputs to zero and drops decision-valid.
- R9: The error output equals the corrected value minus (+ref when the decision is 1, -ref when it is 0).
- R10: A wrong decision is fed back as if it were correct, so it can corrupt the following decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | Sample present this cycle |
| sample_in | input | SAMPLE_W | Signed front-end sample |
| tap_weights | input | NTAPS*WEIGHT_W | Packed signed tap weights, tap 1 in the lowest field |
| ref_amp | input | SAMPLE_W-1 | Unsigned reference amplitude for the error |
| dec_vld | output | 1 | Registered decision valid |
| dec_out | output | 1 | Decision, 1 = +1, 0 = -1 |
| err_out | output | SAMPLE_W+1 | Signed corrected sample minus ideal level |
| weight_bad | output | 1 | Tap weight sum outside the legal range |

## Verification
The hardest case to reach from the ports is error propagation, which needs the loop to make a wrong decision and then feed it back. The stimulus builds samples from a known symbol sequence plus a post-cursor that exactly matches tap one. It then adds a single large negative noise spike, which forces one wrong decision. The next sample is chosen so that the wrong feedback flips its decision too. The bench checks that this second decision disagrees with the transmitted symbol, in addition to matching its own model. Random samples with random weights and gaps in sample-valid cover the rest of the loop.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  typedef enum logic {
    DEC_MINUS = 1'b0,
    DEC_PLUS  = 1'b1
  } dec_e;

  function automatic int log2c(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/dfe_history.sv
module dfe_history #(
  parameter int NTAPS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             new_dec,
  output logic [NTAPS-1:0] hist
);
  // stage 0 is the tap-one decision register; higher stages retime it
  genvar k;
  generate
    for (k = 0; k < NTAPS; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst)      hist[0] <= dfe_pkg::DEC_MINUS;
          else if (adv) hist[0] <= new_dec;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst)      hist[k] <= dfe_pkg::DEC_MINUS;
          else if (adv) hist[k] <= hist[k-1];
        end
      end
    end
  endgenerate

  assert_reset_hist_R8: assert property (@(posedge clk) rst |=> hist == '0);
  assert_hold_hist_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(hist));
  assert_tap1_R3: assert property (@(posedge clk) disable iff (rst)
    adv |=> hist[0] == $past(new_dec));
  generate
    if (NTAPS > 1) begin : g_chk
      assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
        adv |=> hist[NTAPS-1:1] == $past(hist[NTAPS-2:0]));
    end
  endgenerate
endmodule

// File: rtl/dfe_tap_sum.sv
module dfe_tap_sum #(
  parameter int NTAPS    = 4,
  parameter int WEIGHT_W = 6,
  parameter int SHIFT    = 4,
  localparam int SUM_W   = WEIGHT_W + dfe_pkg::log2c(NTAPS) + 1,
  localparam int FB_W    = SUM_W + SHIFT
) (
  input  logic [NTAPS*WEIGHT_W-1:0] weights,
  input  logic [NTAPS-1:0]          hist,
  output logic signed [FB_W-1:0]    fb,
  output logic                      range_bad
);
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(1) << (WEIGHT_W - 1);

  logic signed [SUM_W-1:0] acc;
  logic        [SUM_W-1:0] mag;

  always_comb begin
    acc = '0;
    mag = '0;
    for (int k = 0; k < NTAPS; k++) begin
      logic signed [SUM_W-1:0] w;
      w = SUM_W'($signed(weights[k*WEIGHT_W +: WEIGHT_W]));
      acc = acc + (hist[k] ? w : -w);
      mag = mag + ((w < 0) ? $unsigned(-w) : $unsigned(w));
    end
    fb = FB_W'(acc) <<< SHIFT;
    range_bad = (mag == '0) || (mag >= LIMIT);
  end
endmodule

// File: rtl/dfe_slicer.sv
module dfe_slicer #(
  parameter int SAMPLE_W = 10,
  parameter int FB_W     = 14,
  localparam int DIFF_W  = ((SAMPLE_W > FB_W) ? SAMPLE_W : FB_W) + 1,
  localparam int ERR_W   = SAMPLE_W + 1
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [FB_W-1:0]     fb,
  input  logic        [SAMPLE_W-2:0] ref_amp,
  output logic                       dec,
  output logic signed [ERR_W-1:0]    err
);
  localparam logic signed [DIFF_W-1:0] MAXV = DIFF_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [DIFF_W-1:0] MINV = -MAXV - DIFF_W'(1);

  logic signed [DIFF_W-1:0]   diff;
  logic signed [SAMPLE_W-1:0] corr;
  logic signed [ERR_W-1:0]    lvl;

  always_comb begin
    diff = DIFF_W'(sample) - DIFF_W'(fb);
    if (diff > MAXV)      corr = MAXV[SAMPLE_W-1:0];
    else if (diff < MINV) corr = MINV[SAMPLE_W-1:0];
    else                  corr = diff[SAMPLE_W-1:0];
    dec = ~corr[SAMPLE_W-1];
    lvl = $signed({2'b00, ref_amp});
    err = ERR_W'(corr) - (dec ? lvl : -lvl);
  end
endmodule

// File: rtl/dfe_loop.sv
module dfe_loop #(
  parameter int SAMPLE_W = 10,
  parameter int NTAPS    = 4,
  parameter int WEIGHT_W = 6,
  localparam int SHIFT   = SAMPLE_W - WEIGHT_W,
  localparam int FB_W    = WEIGHT_W + dfe_pkg::log2c(NTAPS) + 1 + SHIFT,
  localparam int ERR_W   = SAMPLE_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sample_vld,
  input  logic [SAMPLE_W-1:0]       sample_in,
  input  logic [NTAPS*WEIGHT_W-1:0] tap_weights,
  input  logic [SAMPLE_W-2:0]       ref_amp,
  output logic                      dec_vld,
  output logic                      dec_out,
  output logic [ERR_W-1:0]          err_out,
  output logic                      weight_bad
);
  logic [NTAPS-1:0]        hist;
  logic signed [FB_W-1:0]  fb;
  logic                    range_bad;
  logic                    dec_now;
  logic signed [ERR_W-1:0] err_now;

  dfe_history #(.NTAPS(NTAPS)) u_hist (
    .clk(clk), .rst(rst), .adv(sample_vld), .new_dec(dec_now), .hist(hist)
  );

  dfe_tap_sum #(.NTAPS(NTAPS), .WEIGHT_W(WEIGHT_W), .SHIFT(SHIFT)) u_sum (
    .weights(tap_weights), .hist(hist), .fb(fb), .range_bad(range_bad)
  );

  dfe_slicer #(.SAMPLE_W(SAMPLE_W), .FB_W(FB_W)) u_slice (
    .sample($signed(sample_in)), .fb(fb), .ref_amp(ref_amp),
    .dec(dec_now), .err(err_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_vld    <= 1'b0;
      dec_out    <= 1'b0;
      err_out    <= '0;
      weight_bad <= 1'b0;
    end else begin
      dec_vld    <= sample_vld;
      weight_bad <= range_bad;
      if (sample_vld) begin
        dec_out <= dec_now;
        err_out <= err_now;
      end
    end
  end

  assert_vld_R3: assert property (@(posedge clk) disable iff (rst)
    dec_vld == $past(sample_vld));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !sample_vld |=> $stable(dec_out) && $stable(err_out));
  assert_zero_weights_R6: assert property (@(posedge clk) disable iff (rst)
    (tap_weights == '0) |=> weight_bad);
  assert_out_matches_hist_R2: assert property (@(posedge clk) disable iff (rst)
    dec_vld |-> dec_out == hist[0]);
  assert_err_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && dec_out) |-> $signed(err_out) >= -$signed({2'b00, $past(ref_amp)}));
endmodule

// File: tb/test_dfe_loop.sv
`timescale 1ns/1ps
module test_dfe_loop;
  localparam int SW = 10, NT = 4, WW = 6;

  logic clk = 1'b0, rst = 1'b1, vld = 1'b0;
  logic [SW-1:0] smp = '0;
  logic [NT*WW-1:0] wts = '0;
  logic [SW-2:0] refa = '0;
  logic dec_vld, dec_out, weight_bad;
  logic [SW:0] err_out;

  int total = 0, bad = 0;
  int w[NT];
  bit mh[NT];
  bit exp_dec = 0, exp_vld = 0, exp_wb = 0;
  int exp_err = 0;
  bit last_dec;
  int last_corr;

  always #5 clk = ~clk;

  dfe_loop #(.SAMPLE_W(SW), .NTAPS(NT), .WEIGHT_W(WW)) i_dfe_loop (
    .clk(clk), .rst(rst), .sample_vld(vld), .sample_in(smp), .tap_weights(wts),
    .ref_amp(refa), .dec_vld(dec_vld), .dec_out(dec_out), .err_out(err_out),
    .weight_bad(weight_bad)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit w_bad();
    int m = 0;
    for (int k = 0; k < NT; k++) m += (w[k] < 0) ? -w[k] : w[k];
    return (m == 0) || (m >= 32);
  endfunction

  task automatic set_w(input int a, input int b, input int c, input int d);
    w[0] = a; w[1] = b; w[2] = c; w[3] = d;
    for (int k = 0; k < NT; k++) wts[k*WW +: WW] = WW'(w[k]);
  endtask

  function automatic int corr_model(input int s);
    int fb = 0, c;
    for (int k = 0; k < NT; k++) fb += (mh[k] ? w[k] : -w[k]) * 16;
    c = s - fb;
    if (c > 511) c = 511;
    if (c < -512) c = -512;
    return c;
  endfunction

  // drives one cycle at the falling edge, checks registered outputs one cycle later
  task automatic step(input bit v, input int s, input string tag);
    @(negedge clk);
    vld = v;
    smp = SW'(s);
    exp_vld = v;
    exp_wb = w_bad();
    if (v) begin
      last_corr = corr_model(s);
      last_dec = (last_corr >= 0);
      exp_dec = last_dec;
      exp_err = last_corr - (last_dec ? int'(refa) : -int'(refa));
      for (int k = NT - 1; k > 0; k--) mh[k] = mh[k-1];
      mh[0] = last_dec;
    end
    @(negedge clk);
    vld = 1'b0;
    chk(dec_out == exp_dec, {tag, " dec"}, dec_out, exp_dec);
    chk($signed(err_out) == exp_err, {tag, " err"}, $signed(err_out), exp_err);
    chk(dec_vld == exp_vld, {tag, " vld"}, dec_vld, exp_vld);
    chk(weight_bad == exp_wb, {tag, " wflag"}, weight_bad, exp_wb);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int k = 0; k < NT; k++) mh[k] = 0;
    set_w(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk(dec_out == 0 && dec_vld == 0 && weight_bad == 0 && err_out == 0, "R8 reset outputs",
        {dec_vld, dec_out, weight_bad}, 0);
    rst = 1'b0;
    refa = 9'd100;
    // R8 + R1: history -1 gives fb = -sum(w)*16
    set_w(4, 2, 1, 1);
    step(1, -100, "R8 history cleared to -1");
    chk(exp_dec == 1 && last_corr == 28, "R8 model", last_corr, 28);

    // R1: corrected exactly zero decides +1
    set_w(1, 0, 0, 0);
    step(1, (mh[0] ? 16 : -16), "R1 tie decides plus");
    chk(dec_out == 1, "R1 tie", dec_out, 1);

    // R2 / R4: only tap 3 active, pattern through the chain
    set_w(0, 0, 10, 0);
    step(1, 300, "R4 chain a");
    step(1, -300, "R4 chain b");
    step(1, -300, "R4 chain c");
    step(1, 100, "R2 tap3 uses decision three back");
    step(1, -140, "R4 tap3 sign");

    // R7: invalid samples leave everything alone
    step(0, -500, "R7 ignored sample");
    step(0, 500, "R7 ignored sample 2");
    step(1, 5, "R7 history unchanged after gap");

    // R5: saturation both ways
    set_w(31, 31, 31, 31);
    step(1, -512, "R5 saturate");
    step(1, 511, "R5 saturate hi");
    step(1, 511, "R5 saturate again");
    step(1, -512, "R5 saturate lo");

    // R6: range boundaries of total absolute weight
    set_w(10, -10, 5, 6);
    step(0, 0, "R6 sum 31 legal");
    set_w(10, -10, 6, 6);
    step(0, 0, "R6 sum 32 flagged");
    set_w(-32, 0, 0, 0);
    step(0, 0, "R6 negative full scale flagged");
    set_w(0, 0, 0, 0);
    step(0, 0, "R6 zero flagged");

    // R10: error propagation; tap1 = 8 -> 128 units, channel post-cursor 128
    refa = 9'd200;
    set_w(8, 0, 0, 0);
    step(1, -328, "R10 prime");
    step(1, -328, "R10 prime 2");
    step(1, 72, "R10 clean plus");
    chk(dec_out == 1, "R10 correct decision", dec_out, 1);
    step(1, 328 - 400, "R10 noise hit");
    chk(dec_out == 0, "R10 forced wrong decision", dec_out, 0);
    step(1, -72, "R10 propagated");
    chk(dec_out == 1, "R10 wrong feedback flips next symbol (sent -1)", dec_out, 1);
    chk($signed(err_out) == -144, "R10 propagated err R9", $signed(err_out), -144);
    step(1, -328, "R10 recovers");
    chk(dec_out == 0, "R10 recovered", dec_out, 0);

    // R3 / R9: random traffic
    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) begin
        set_w(int'($urandom_range(16)) - 8, int'($urandom_range(16)) - 8,
              int'($urandom_range(16)) - 8, int'($urandom_range(16)) - 8);
        refa = 9'($urandom_range(511));
      end
      step(($urandom_range(3) != 0), int'($urandom_range(1023)) - 512, "R3 R9 random");
    end

    // R8: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(dec_out == 0 && err_out == 0 && dec_vld == 0, "R8 reset again", dec_out, 0);
    for (int k = 0; k < NT; k++) mh[k] = 0;
    exp_dec = 0; exp_err = 0;
    set_w(3, 3, 3, 3);
    refa = 9'd50;
    step(1, -200, "R8 history -1 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule